// File: doc/BRIEF.md
# Requester ID to PE range mapper

This block keeps one mapping record per partitionable endpoint (PE) and answers, in the same cycle, which PE owns a given 16-bit PCI requester ID. The requester ID is split into an 8-bit bus number (bits 15:8), a 5-bit device number (bits 7:3) and a 3-bit function number (bits 2:0). Each record holds a base requester ID, a 3-bit bus compare code, a device compare flag, a function compare flag and a valid bit. Together these define a range of requester IDs. A wildcard on bus high bits, on device or on function widens that range.

A write port maps a PE by loading its record, or unmaps it by clearing its valid bit. The write port rejects a bad PE number, action or bus code and leaves every record unchanged in that case. The lookup port is combinational. It returns a hit flag and the lowest-numbered matching PE. It also exports the raw per-PE match vector, so that neighbouring blocks can use every owner of an ID and not only the winner.

Top module: `rid_pe_mapper`

## Requirements
- R1: After reset every PE is unmapped: `match_vec` is all zero, `lk_hit` is 0 and `lk_pe` is 0.
- R2: A mapped PE with bus compare code 0 matches every bus number.
- R3: A bus compare code c from 1 to 6 matches when the top c+1 bits of the lookup bus equal the top c+1 bits of the base bus. Code 1 uses 2 bits and code 6 uses 7 bits.
- R4: Bus compare code 7 matches only when all 8 bus bits are equal.
- R5: With the device compare flag at 0, any device number matches. With the flag at 1, the device number must equal the base device.
- R6: The function compare flag works on the function number in the same way that R5 describes for the device number.
- R7: `wr_action` 1 maps the PE with the written record, and `wr_action` 0 unmaps it. An unmapped PE never sets its `match_vec` bit.
- R8: A write with `wr_action` 2 or 3 raises `wr_err` in that cycle and changes no record.
- R9: A write with `wr_bus_code` above 7 raises `wr_err` in that cycle and changes no record.
- R10: A write with `wr_pe` of NUM_PE or above raises `wr_err` in that cycle and changes no record. `wr_err` is 0 whenever `wr_en` is 0.
- R11: When at least one PE matches, `lk_hit` is 1 and `lk_pe` is the lowest matching PE number. When no PE matches, `lk_hit` is 0 and `lk_pe` is 0.
- R12: `match_vec[i]` is 1 exactly when PE i is mapped and its record covers `lk_rid`.
- R13: The lookup outputs follow `lk_rid` in the same cycle. An accepted write shows up on the lookup outputs only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe |
| wr_pe | input | PE_IN_W | PE number being written |
| wr_action | input | 2 | 1 = map, 0 = unmap, other values are rejected |
| wr_bus_code | input | 4 | Bus compare code, 0 to 7 valid |
| wr_bdf | input | 16 | Base requester ID {bus, dev, fn} |
| wr_dev_cmp | input | 1 | Require an exact device match |
| wr_fn_cmp | input | 1 | Require an exact function match |
| wr_err | output | 1 | Current write is rejected |
| lk_rid | input | 16 | Requester ID to look up |
| lk_hit | output | 1 | At least one PE matches |
| lk_pe | output | PE_IDX_W | Lowest matching PE number |
| match_vec | output | NUM_PE | Per-PE match flags |

## Verification
Every record is visible at the ports through `match_vec`. A corrupted base field, compare code or valid bit therefore shows up in the first cycle after the bad write, provided the lookup ID falls inside the affected range. The bench keeps a behavioural copy of every record and compares the match vector, the hit flag, the winner and the error flag on every clock. Writes that are rejected are followed straight away by lookups that would expose a changed record. Lookups taken in the same cycle as a write check that the new contents stay hidden until the edge.

// File: rtl/rid_pe_pkg.sv
package rid_pe_pkg;
  localparam int RID_W  = 16;
  localparam int BUS_W  = 8;
  localparam int DEV_W  = 5;
  localparam int FN_W   = 3;
  localparam int CODE_W = 3;

  typedef enum logic [1:0] {
    ACT_UNMAP = 2'd0,
    ACT_MAP   = 2'd1
  } pe_act_e;

  typedef struct packed {
    logic              valid;
    logic [CODE_W-1:0] bus_code;
    logic              dev_cmp;
    logic              fn_cmp;
    logic [BUS_W-1:0]  bus;
    logic [DEV_W-1:0]  dev;
    logic [FN_W-1:0]   fn;
  } pe_rec_t;

  // code 0: no bus bits compared; code c>0: top c+1 bits compared
  function automatic logic [BUS_W-1:0] bus_mask(input logic [CODE_W-1:0] code);
    logic [BUS_W-1:0] m;
    if (code == '0) m = '0;
    else            m = {BUS_W{1'b1}} << (3'd7 - code);
    return m;
  endfunction
endpackage

// File: rtl/rid_pe_wr_dec.sv
module rid_pe_wr_dec
  import rid_pe_pkg::*;
#(
  parameter int NUM_PE  = 12,
  parameter int PE_IN_W = 8
) (
  input  logic               wr_en,
  input  logic [PE_IN_W-1:0] wr_pe,
  input  logic [1:0]         wr_action,
  input  logic [3:0]         wr_bus_code,
  input  logic [RID_W-1:0]   wr_bdf,
  input  logic               wr_dev_cmp,
  input  logic               wr_fn_cmp,
  output logic [NUM_PE-1:0]  we_vec,
  output pe_rec_t            wr_rec,
  output logic               wr_err
);
  logic pe_ok;
  logic act_ok;
  logic code_ok;
  logic accept;

  always_comb begin
    pe_ok   = (wr_pe < PE_IN_W'(NUM_PE));
    act_ok  = (wr_action == ACT_MAP) || (wr_action == ACT_UNMAP);
    code_ok = !wr_bus_code[3];
    accept  = wr_en && pe_ok && act_ok && code_ok;
    wr_err  = wr_en && !(pe_ok && act_ok && code_ok);
  end

  always_comb begin
    wr_rec.valid    = (wr_action == ACT_MAP);
    wr_rec.bus_code = wr_bus_code[CODE_W-1:0];
    wr_rec.dev_cmp  = wr_dev_cmp;
    wr_rec.fn_cmp   = wr_fn_cmp;
    wr_rec.bus      = wr_bdf[15:8];
    wr_rec.dev      = wr_bdf[7:3];
    wr_rec.fn       = wr_bdf[2:0];
  end

  for (genvar i = 0; i < NUM_PE; i++) begin : g_we
    assign we_vec[i] = accept && (wr_pe == PE_IN_W'(i));
  end
endmodule

// File: rtl/rid_pe_entry.sv
module rid_pe_entry
  import rid_pe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  pe_rec_t          wr_rec,
  input  logic [RID_W-1:0] lk_rid,
  output logic             hit
);
  pe_rec_t rec_q;
  pe_rec_t rec_d;

  always_comb begin
    rec_d = rec_q;
    if (we) rec_d = wr_rec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rec_q <= '0;
    else if (we) rec_q <= rec_d;
  end

  logic [BUS_W-1:0] mask;
  logic             bus_ok;
  logic             dev_ok;
  logic             fn_ok;

  always_comb begin
    mask   = bus_mask(rec_q.bus_code);
    bus_ok = ((lk_rid[15:8] ^ rec_q.bus) & mask) == '0;
    dev_ok = !rec_q.dev_cmp || (lk_rid[7:3] == rec_q.dev);
    fn_ok  = !rec_q.fn_cmp  || (lk_rid[2:0] == rec_q.fn);
    hit    = rec_q.valid && bus_ok && dev_ok && fn_ok;
  end
endmodule

// File: rtl/rid_pe_prio.sv
module rid_pe_prio #(
  parameter int N     = 12,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     vec,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
    hit = |vec;
  end
endmodule

// File: rtl/rid_pe_mapper.sv
module rid_pe_mapper
  import rid_pe_pkg::*;
#(
  parameter int NUM_PE   = 12,
  parameter int PE_IN_W  = 8,
  localparam int PE_IDX_W = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [PE_IN_W-1:0]  wr_pe,
  input  logic [1:0]          wr_action,
  input  logic [3:0]          wr_bus_code,
  input  logic [15:0]         wr_bdf,
  input  logic                wr_dev_cmp,
  input  logic                wr_fn_cmp,
  output logic                wr_err,
  input  logic [15:0]         lk_rid,
  output logic                lk_hit,
  output logic [PE_IDX_W-1:0] lk_pe,
  output logic [NUM_PE-1:0]   match_vec
);
  logic [NUM_PE-1:0] we_vec;
  pe_rec_t           wr_rec;

  rid_pe_wr_dec #(.NUM_PE(NUM_PE), .PE_IN_W(PE_IN_W)) u_dec (
    .wr_en      (wr_en),
    .wr_pe      (wr_pe),
    .wr_action  (wr_action),
    .wr_bus_code(wr_bus_code),
    .wr_bdf     (wr_bdf),
    .wr_dev_cmp (wr_dev_cmp),
    .wr_fn_cmp  (wr_fn_cmp),
    .we_vec     (we_vec),
    .wr_rec     (wr_rec),
    .wr_err     (wr_err)
  );

  for (genvar i = 0; i < NUM_PE; i++) begin : g_pe
    rid_pe_entry u_entry (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we_vec[i]),
      .wr_rec(wr_rec),
      .lk_rid(lk_rid),
      .hit   (match_vec[i])
    );
  end

  rid_pe_prio #(.N(NUM_PE), .IDX_W(PE_IDX_W)) u_prio (
    .vec(match_vec),
    .hit(lk_hit),
    .idx(lk_pe)
  );
endmodule

// File: rtl/rid_pe_mapper_chk.sv
module rid_pe_mapper_chk #(
  parameter int NUM_PE   = 12,
  parameter int PE_IN_W  = 8,
  parameter int PE_IDX_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [PE_IN_W-1:0]  wr_pe,
  input logic [1:0]          wr_action,
  input logic [3:0]          wr_bus_code,
  input logic [15:0]         wr_bdf,
  input logic                wr_dev_cmp,
  input logic                wr_fn_cmp,
  input logic                wr_err,
  input logic [15:0]         lk_rid,
  input logic                lk_hit,
  input logic [PE_IDX_W-1:0] lk_pe,
  input logic [NUM_PE-1:0]   match_vec
);
  logic [PE_IDX_W-1:0] pe_idx;
  logic                bad_wr;
  assign pe_idx = wr_pe[PE_IDX_W-1:0];
  assign bad_wr = wr_en && ((wr_pe >= PE_IN_W'(NUM_PE)) || wr_action[1] || wr_bus_code[3]);

  // R8 R9 R10: parameter errors flagged, nothing flagged without a write
  p_err_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err == bad_wr);

  // R11: hit follows the match vector
  p_hit_any_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit == (match_vec != '0));

  // R11: winner is a matching PE with no lower matching PE
  p_lowest_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (match_vec[lk_pe] &&
                ((match_vec & ((NUM_PE'(1) << lk_pe) - NUM_PE'(1))) == '0)));

  // R11: no hit reports PE 0
  p_miss_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_pe == '0));

  // R7: an accepted unmap silences that PE
  p_unmap_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_err && wr_action == 2'd0) |=> !match_vec[$past(pe_idx)]);

  // R4 R7 R13: exact-ID map matches its own ID after the edge
  p_map_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_err && wr_action == 2'd1 && wr_bus_code == 4'd7 && wr_dev_cmp && wr_fn_cmp)
    |=> ((lk_rid != $past(wr_bdf)) || match_vec[$past(pe_idx)]));

  // R8 R9 R10: a rejected write leaves lookups unchanged
  p_reject_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_err) |=> (!$stable(lk_rid) || $past(wr_en && !wr_err) || $stable(match_vec)));
endmodule

bind rid_pe_mapper rid_pe_mapper_chk #(
  .NUM_PE(NUM_PE), .PE_IN_W(PE_IN_W), .PE_IDX_W(PE_IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pe(wr_pe), .wr_action(wr_action),
  .wr_bus_code(wr_bus_code), .wr_bdf(wr_bdf), .wr_dev_cmp(wr_dev_cmp),
  .wr_fn_cmp(wr_fn_cmp), .wr_err(wr_err), .lk_rid(lk_rid), .lk_hit(lk_hit),
  .lk_pe(lk_pe), .match_vec(match_vec)
);

// File: tb/tb_rid_pe_mapper.sv
module tb_rid_pe_mapper;
  localparam int NUM_PE   = 12;
  localparam int PE_IN_W  = 8;
  localparam int PE_IDX_W = 4;

  logic                clk;
  logic                rst_n;
  logic                wr_en;
  logic [PE_IN_W-1:0]  wr_pe;
  logic [1:0]          wr_action;
  logic [3:0]          wr_bus_code;
  logic [15:0]         wr_bdf;
  logic                wr_dev_cmp;
  logic                wr_fn_cmp;
  logic                wr_err;
  logic [15:0]         lk_rid;
  logic                lk_hit;
  logic [PE_IDX_W-1:0] lk_pe;
  logic [NUM_PE-1:0]   match_vec;

  rid_pe_mapper #(.NUM_PE(NUM_PE), .PE_IN_W(PE_IN_W)) dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // behavioural record store
  int m_val [NUM_PE];
  int m_code[NUM_PE];
  int m_dc  [NUM_PE];
  int m_fc  [NUM_PE];
  int m_bus [NUM_PE];
  int m_dev [NUM_PE];
  int m_fn  [NUM_PE];

  function automatic bit m_match(int i, int rid);
    int b;
    int d;
    int f;
    int sh;
    b = (rid >> 8) & 255;
    d = (rid >> 3) & 31;
    f = rid & 7;
    if (m_val[i] == 0) return 0;
    if (m_code[i] != 0) begin
      sh = 7 - m_code[i];
      if ((b >> sh) != (m_bus[i] >> sh)) return 0;
    end
    if (m_dc[i] != 0 && d != m_dev[i]) return 0;
    if (m_fc[i] != 0 && f != m_fn[i]) return 0;
    return 1;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit we, int pe, int act, int bdf, int code, bit dc, bit fc,
                      int rid, string tag);
    int  ev;
    int  ep;
    bit  eh;
    bit  ee;
    @(negedge clk);
    wr_en       = we;
    wr_pe       = PE_IN_W'(pe);
    wr_action   = 2'(act);
    wr_bus_code = 4'(code);
    wr_bdf      = 16'(bdf);
    wr_dev_cmp  = dc;
    wr_fn_cmp   = fc;
    lk_rid      = 16'(rid);
    #2;
    ev = 0; ep = 0; eh = 0;
    for (int i = NUM_PE - 1; i >= 0; i--) begin
      if (m_match(i, rid)) begin
        ev = ev | (1 << i);
        ep = i;
        eh = 1;
      end
    end
    ee = we && (pe >= NUM_PE || act > 1 || code > 7);
    chk(int'(match_vec) == ev, tag, "match_vec R12", int'(match_vec), ev);
    chk(lk_hit == eh, tag, "lk_hit R11", int'(lk_hit), int'(eh));
    chk(int'(lk_pe) == ep, tag, "lk_pe R11", int'(lk_pe), ep);
    chk(wr_err == ee, tag, "wr_err", int'(wr_err), int'(ee));
    @(posedge clk);
    if (we && !ee) begin
      m_val[pe]  = (act == 1);
      m_code[pe] = code;
      m_dc[pe]   = dc;
      m_fc[pe]   = fc;
      m_bus[pe]  = (bdf >> 8) & 255;
      m_dev[pe]  = (bdf >> 3) & 31;
      m_fn[pe]   = bdf & 7;
    end
  endtask

  task automatic look(int rid, string tag);
    step(0, 0, 0, 0, 0, 0, 0, rid, tag);
  endtask

  function automatic int bdf_of(int b, int d, int f);
    return (b << 8) | (d << 3) | f;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NUM_PE; i++) m_val[i] = 0;
    rst_n = 0; wr_en = 0; wr_pe = '0; wr_action = '0; wr_bus_code = '0;
    wr_bdf = '0; wr_dev_cmp = 0; wr_fn_cmp = 0; lk_rid = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: reset state, nothing mapped
    look(16'h0000, "R1");
    look(16'hFFFF, "R1");

    // R4 R13: exact map of PE3; same-cycle lookup must still miss
    step(1, 3, 1, bdf_of(8'h12, 5, 3), 7, 1, 1, bdf_of(8'h12, 5, 3), "R13");
    look(bdf_of(8'h12, 5, 3), "R4");
    look(bdf_of(8'h13, 5, 3), "R4");
    // R6: function flag
    look(bdf_of(8'h12, 5, 2), "R6");
    step(1, 4, 1, bdf_of(8'h20, 1, 6), 7, 1, 0, 0, "R6");
    look(bdf_of(8'h20, 1, 0), "R6");
    look(bdf_of(8'h20, 2, 0), "R5");

    // R3: code 2 (top 3 bits) and code 1 (top 2 bits) and code 6
    step(1, 5, 1, bdf_of(8'hA0, 0, 0), 2, 0, 0, 0, "R3");
    look(bdf_of(8'hBF, 9, 1), "R3");
    look(bdf_of(8'hC0, 9, 1), "R3");
    step(1, 6, 1, bdf_of(8'h40, 0, 0), 1, 0, 0, 0, "R3");
    look(bdf_of(8'h7F, 0, 0), "R3");
    look(bdf_of(8'h80, 0, 0), "R3");
    step(1, 8, 1, bdf_of(8'hE4, 0, 0), 6, 0, 0, 0, "R3");
    look(bdf_of(8'hE5, 3, 3), "R3");
    look(bdf_of(8'hE6, 3, 3), "R3");

    // R2 R5: bus wildcard, exact device
    step(1, 7, 1, bdf_of(8'h00, 9, 0), 0, 1, 0, 0, "R2");
    look(bdf_of(8'hF3, 9, 5), "R2");
    look(bdf_of(8'hF3, 8, 5), "R5");

    // R11: full wildcard on PE2 beats PE3
    step(1, 2, 1, 0, 0, 0, 0, 0, "R11");
    look(bdf_of(8'h12, 5, 3), "R11");
    look(bdf_of(8'h77, 1, 1), "R11");

    // R7: unmap PE2, PE3 wins again
    step(1, 2, 0, 0, 0, 0, 0, bdf_of(8'h12, 5, 3), "R7");
    look(bdf_of(8'h12, 5, 3), "R7");

    // R8: bad actions on PE3 rejected
    step(1, 3, 2, 0, 0, 0, 0, bdf_of(8'h12, 5, 3), "R8");
    look(bdf_of(8'h12, 5, 3), "R8");
    step(1, 3, 3, 0, 0, 0, 0, bdf_of(8'h12, 5, 3), "R8");
    look(bdf_of(8'h12, 5, 3), "R8");
    // R9: bus code above 7
    step(1, 0, 1, 0, 8, 0, 0, 16'h1234, "R9");
    look(16'h1234, "R9");
    step(1, 0, 1, 0, 15, 0, 0, 16'h4321, "R9");
    look(16'h4321, "R9");
    // R10: PE number out of range
    step(1, NUM_PE, 1, 0, 0, 0, 0, 16'h5555, "R10");
    look(16'h5555, "R10");
    step(1, 255, 1, 0, 0, 0, 0, 16'hAAAA, "R10");
    look(16'hAAAA, "R10");
    // R10: highest valid PE accepted
    step(1, NUM_PE - 1, 1, bdf_of(8'h99, 4, 4), 7, 1, 1, 0, "R10");
    look(bdf_of(8'h99, 4, 4), "R10");

    // R12: mixed traffic
    for (int n = 0; n < 400; n++) begin
      int pe;
      int rid;
      int bdf;
      pe  = $urandom_range(0, NUM_PE + 1);
      bdf = $urandom_range(0, 65535);
      rid = (n % 2 == 0) ? bdf_of(m_bus[n % NUM_PE], m_dev[n % NUM_PE], m_fn[n % NUM_PE])
                         : $urandom_range(0, 65535);
      if (n % 3 == 0)
        step(1, pe, $urandom_range(0, 2), bdf, $urandom_range(0, 8),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), rid, "R12");
      else
        look(rid, "R12");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule